// File: doc/BRIEF.md
# Iterative AES Encryption Round Engine

This block encrypts one 128-bit block at a time with AES, under a 128-, 192- or 256-bit key. It does not expand keys itself. Each cycle it puts a round number on `rk_idx` and expects the matching round key on `rk_key` in the same cycle, combinationally, from an external key scheduler. The cipher state goes through one 64-bit wide substitution stage and one 64-bit wide column-mixing stage. Each round therefore takes three clock cycles. The initial key addition and the output capture add two more cycles, so a block takes exactly 2 + 3 × rounds cycles.

A block is offered with `in_valid`/`in_ready` together with a key-length code. An accepted block first sits in a single holding register. It moves into the engine once the engine is free. This lets one block wait while another is being encrypted, so a steady stream finishes one block every 32, 38 or 44 cycles. The ciphertext appears on `out_block` with a one-cycle `out_valid` pulse.

Top module: `aes_iter_core`

## Requirements
- R1: The key-length code taken with a block sets its round count. The codes are 2'b00 → 10 rounds, 2'b01 → 12 rounds, and 2'b10 or 2'b11 → 14 rounds.
- R2: When the engine is idle and nothing is held, `out_valid` rises exactly 2 + 3 × rounds rising edges after the edge that accepts the block (32, 38 or 44).
- R3: `out_valid` is high for exactly one cycle per block, and `out_block` carries that block's ciphertext during that cycle.
- R4: The ciphertext equals AES encryption of the block under the supplied round keys, including the published known-answer results for all three key sizes.
- R5: `in_ready` is low exactly while the holding register is occupied. At most one block waits behind the block being encrypted, and a further block is refused until the current one completes.
- R6: With the holding register refilled continuously, consecutive `out_valid` pulses are 2 + 3 × rounds cycles apart.
- R7: `rk_idx` is 0 while the engine is idle, so key 0 is added when a block enters. During round r it is r. The last round skips column mixing.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: `in_block` and `in_klen` are ignored whenever `in_ready` is low, even if `in_valid` is high.
- R10: The key-length code is captured at acceptance. Changing `in_klen` afterwards does not change the round count or the result of a block already accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Holding register empty, block can be taken |
| in_block | input | 128 | Plaintext, byte 0 in bits 127:120 |
| in_klen | input | 2 | Key-length code (see R1) |
| rk_idx | output | 4 | Round key number requested this cycle |
| rk_key | input | 128 | Round key for `rk_idx`, same cycle |
| out_valid | output | 1 | One-cycle ciphertext strobe |
| out_block | output | 128 | Ciphertext |

## Verification
The bench checks the full schedule of a queued block: it drains the waiting block and then presents junk with `in_valid` high while `in_ready` is low. An engine that starts the waiting block in the same cycle it emits a result would finish each block one cycle early. An engine that takes the junk would emit the wrong ciphertext. The bench uses the reserved key-length code and changes `in_klen` after acceptance. A design that decodes the code late, or misreads it, would run the wrong number of rounds and its strobe would come on the wrong cycle. Known-answer blocks for all three key sizes show up a wrong last round, such as mixing columns in the final round, and byte-order slips in the row shift.

// File: rtl/aes_it_pkg.sv
package aes_it_pkg;

  localparam int BLK_W    = 128;
  localparam int HALF_W   = BLK_W / 2;
  localparam int COL_W    = 32;
  localparam int RK_IDX_W = 4;
  localparam int KL_W     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting, key 0 presented
    ST_SUBHI,  // substitute upper half (columns 0,1)
    ST_SUBLO,  // substitute lower half, shift rows, mix+key columns 0,1
    ST_MIXLO,  // mix+key columns 2,3
    ST_FIN     // capture result
  } stage_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa, bb;
    p = 8'h00; aa = a; bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) p = p ^ aa;
      aa = xtime(aa);
      bb = bb >> 1;
    end
    return p;
  endfunction

  // multiplicative inverse as a^254, then affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] r, sq;
    r = 8'h01; sq = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gmul(r, sq);
      sq = gmul(sq, sq);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  // byte k = 4*col + row sits at bits [127-8k -: 8]
  function automatic logic [127:0] shift_rows(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8*(4*c + r) -: 8] = s[127 - 8*(4*((c + r) % 4) + r) -: 8];
    return o;
  endfunction

  function automatic logic [RK_IDX_W-1:0] rounds_for(input logic [KL_W-1:0] kl);
    case (kl)
      2'b00:   return RK_IDX_W'(10);
      2'b01:   return RK_IDX_W'(12);
      default: return RK_IDX_W'(14);
    endcase
  endfunction

endpackage

// File: rtl/aes_sub64.sv
module aes_sub64 #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import aes_it_pkg::*;
  localparam int NBYTES = W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_sb
    assign dout[8*g +: 8] = sbox(din[8*g +: 8]);
  end
endmodule

// File: rtl/aes_mix64.sv
module aes_mix64 #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  input  logic         bypass,
  output logic [W-1:0] dout
);
  import aes_it_pkg::*;
  localparam int NCOLS = W / COL_W;

  for (genvar g = 0; g < NCOLS; g++) begin : g_col
    assign dout[COL_W*g +: COL_W] = bypass ? din[COL_W*g +: COL_W]
                                           : mix_col(din[COL_W*g +: COL_W]);
  end
endmodule

// File: rtl/aes_ctl.sv
module aes_ctl
  import aes_it_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [KL_W-1:0]     start_klen,
  output stage_t              stage,
  output logic [RK_IDX_W-1:0] rnd,
  output logic                last
);
  logic [RK_IDX_W-1:0] nr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= ST_IDLE;
      rnd   <= '0;
      nr    <= RK_IDX_W'(10);
    end else begin
      case (stage)
        ST_IDLE: if (start) begin
          stage <= ST_SUBHI;
          rnd   <= RK_IDX_W'(1);
          nr    <= rounds_for(start_klen);
        end
        ST_SUBHI: stage <= ST_SUBLO;
        ST_SUBLO: stage <= ST_MIXLO;
        ST_MIXLO: if (rnd == nr) stage <= ST_FIN;
                  else begin
                    stage <= ST_SUBHI;
                    rnd   <= rnd + RK_IDX_W'(1);
                  end
        ST_FIN: begin
          stage <= ST_IDLE;
          rnd   <= '0;
        end
        default: stage <= ST_IDLE;
      endcase
    end
  end

  assign last = (rnd == nr);

  // R1: only the three legal round counts are ever run
  a_r1_round_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != ST_IDLE) |-> (nr == 4'd10 || nr == 4'd12 || nr == 4'd14));

  // R7: inside a block the key index stays within 1..nr
  a_r7_rk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_SUBHI || stage == ST_SUBLO || stage == ST_MIXLO)
      |-> (rnd >= 4'd1 && rnd <= nr));

  // R2: the last round's final step leads straight to capture
  a_r2_last_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_MIXLO && last) |=> (stage == ST_FIN));

  // R6: capture is always followed by one idle cycle with key 0
  a_r6_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_FIN) |=> (stage == ST_IDLE && rnd == '0));
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_it_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BLK_W-1:0]    in_block,
  input  logic [KL_W-1:0]     in_klen,
  output logic [RK_IDX_W-1:0] rk_idx,
  input  logic [BLK_W-1:0]    rk_key,
  output logic                out_valid,
  output logic [BLK_W-1:0]    out_block
);
  logic              hold_full;
  logic [BLK_W-1:0]  hold_blk;
  logic [KL_W-1:0]   hold_kl;
  logic [BLK_W-1:0]  st;
  stage_t            stage;
  logic [RK_IDX_W-1:0] rnd;
  logic              last;

  // named events
  logic accept, go, fin;
  assign accept   = in_valid && in_ready;
  assign go       = hold_full && (stage == ST_IDLE);
  assign fin      = (stage == ST_FIN);
  assign in_ready = !hold_full;
  assign rk_idx   = rnd;

  aes_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (go),
    .start_klen (hold_kl),
    .stage      (stage),
    .rnd        (rnd),
    .last       (last)
  );

  // one 64-bit substitution stage, shared by both halves
  logic [HALF_W-1:0] sub_in, sub_out;
  assign sub_in = (stage == ST_SUBHI) ? st[BLK_W-1:HALF_W] : st[HALF_W-1:0];

  aes_sub64 #(.W(HALF_W)) u_sub (.din(sub_in), .dout(sub_out));

  logic [BLK_W-1:0] shifted;
  assign shifted = shift_rows({st[BLK_W-1:HALF_W], sub_out});

  // one 64-bit column-mix stage, shared by both halves
  logic [HALF_W-1:0] mix_in, mix_out;
  assign mix_in = (stage == ST_SUBLO) ? shifted[BLK_W-1:HALF_W] : st[HALF_W-1:0];

  aes_mix64 #(.W(HALF_W)) u_mix (.din(mix_in), .bypass(last), .dout(mix_out));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_blk  <= '0;
      hold_kl   <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_blk  <= in_block;
      hold_kl   <= in_klen;
    end else if (go) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      case (stage)
        ST_IDLE:  if (go) st <= hold_blk ^ rk_key;
        ST_SUBHI: st[BLK_W-1:HALF_W] <= sub_out;
        ST_SUBLO: st <= {mix_out ^ rk_key[BLK_W-1:HALF_W], shifted[HALF_W-1:0]};
        ST_MIXLO: st[HALF_W-1:0] <= mix_out ^ rk_key[HALF_W-1:0];
        default:  st <= st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_block <= '0;
    end else begin
      out_valid <= fin;
      if (fin) out_block <= st;
    end
  end

  // R3: result strobe never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: a waiting block is kept intact until the engine takes it
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !go) |=> (hold_full && $stable(hold_blk) && $stable(hold_kl)));

  // R5: a block entering the engine frees the holding register
  a_r5_go_frees: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> in_ready);

  // R7: key 0 is presented whenever a block enters
  a_r7_key0_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (rk_idx == '0));
endmodule

// File: tb/aes_iter_core_tb.sv
`timescale 1ns/1ps
module aes_iter_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic [1:0]   in_klen = '0;
  logic [3:0]   rk_idx;
  logic [127:0] rk_key;
  logic         out_valid;
  logic [127:0] out_block;

  always #2.5 clk = ~clk;

  aes_iter_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_klen(in_klen), .rk_idx(rk_idx), .rk_key(rk_key),
    .out_valid(out_valid), .out_block(out_block)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int acc_cyc = 0;
  logic [127:0] rk_tab [15];
  logic [7:0]   tsb [256];
  int out_cyc_q[$];
  logic [127:0] out_dat_q[$];

  assign rk_key = rk_tab[rk_idx];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- behavioural AES pieces ----
  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {tsb[w[31:24]], tsb[w[23:16]], tsb[w[15:8]], tsb[w[7:0]]};
  endfunction

  task automatic build_keys(input logic [255:0] key, input int nk);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    int nr = nk + 6;
    for (int i = 0; i < nk; i++) w[i] = key[255 - 32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = tmul(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) t = subw(t);
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < 15; r++)
      rk_tab[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input int nr);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk_tab[0][127-8*i -: 8];
    for (int r = 1; r <= nr; r++) begin
      for (int i = 0; i < 16; i++) s[i] = tsb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) t[4*c+q] = s[4*((c+q)%4)+q];
      for (int c = 0; c < 4; c++) begin
        if (r == nr) for (int q = 0; q < 4; q++) s[4*c+q] = t[4*c+q];
        else for (int q = 0; q < 4; q++)
          s[4*c+q] = tmul(t[4*c+q], 8'h02) ^ tmul(t[4*c+(q+1)%4], 8'h03)
                   ^ t[4*c+(q+2)%4] ^ t[4*c+(q+3)%4];
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk_tab[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  function automatic int nr_of(input logic [1:0] kl);
    return (kl == 2'b00) ? 10 : (kl == 2'b01) ? 12 : 14;
  endfunction

  // ---- cycle model ----
  bit           m_hold = 0;
  logic [127:0] m_hold_exp;
  int           m_hold_nr;
  int           m_eng_cnt = 0;
  logic [127:0] m_eng_exp;
  bit           m_exp_valid = 0;
  logic [127:0] m_exp_data = '0;

  always @(posedge clk) begin
    bit go, acc;
    if (!rst_n) begin
      m_hold = 0; m_eng_cnt = 0; m_exp_valid = 0;
    end else begin
      go  = (m_eng_cnt == 0) && m_hold;
      acc = in_valid && !m_hold;
      m_exp_valid = 0;
      if (m_eng_cnt > 0) begin
        m_eng_cnt--;
        if (m_eng_cnt == 0) begin m_exp_valid = 1; m_exp_data = m_eng_exp; end
      end
      if (go) begin
        m_eng_cnt = 3*m_hold_nr + 1;
        m_eng_exp = m_hold_exp;
        m_hold = 0;
      end
      if (acc) begin
        m_hold = 1;
        m_hold_nr = nr_of(in_klen);
        m_hold_exp = ref_enc(in_block, m_hold_nr);
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == m_exp_valid, "R3 out_valid timing", 128'(out_valid), 128'(m_exp_valid));
      chk(in_ready == !m_hold, "R5 in_ready", 128'(in_ready), 128'(!m_hold));
      if (m_exp_valid)
        chk(out_block == m_exp_data, "R4 ciphertext vs model", out_block, m_exp_data);
      if (out_valid) begin
        out_cyc_q.push_back(cyc);
        out_dat_q.push_back(out_block);
      end
    end
  end

  task automatic send(input logic [127:0] blk, input logic [1:0] kl);
    @(negedge clk);
    while (!in_ready) begin   // R9: junk offered while not ready
      in_valid = 1'b1;
      in_block = {$urandom, $urandom, $urandom, $urandom};
      in_klen  = ~kl;
      @(negedge clk);
    end
    in_valid = 1'b1; in_block = blk; in_klen = kl;
    @(negedge clk);
    acc_cyc  = cyc;
    in_valid = 1'b0;
    in_block = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic drain();
    while (m_hold || m_eng_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    out_cyc_q.delete();
    out_dat_q.delete();
  endtask

  task automatic kat(input logic [127:0] pt, input logic [1:0] kl, input logic [127:0] ct, input string tag);
    send(pt, kl);
    while (out_cyc_q.size() == 0) @(negedge clk);
    chk(out_dat_q[0] == ct, {"R4 known answer ", tag}, out_dat_q[0], ct);
    chk(out_cyc_q[0] - acc_cyc == 2 + 3*nr_of(kl), {"R2 latency ", tag, " (R1 rounds)"},
        128'(out_cyc_q[0] - acc_cyc), 128'(2 + 3*nr_of(kl)));
    drain();
  endtask

  task automatic stream(input int n, input logic [1:0] kl, input string tag);
    for (int i = 0; i < n; i++) send({$urandom, $urandom, $urandom, $urandom}, kl);
    while (out_cyc_q.size() < n) @(negedge clk);
    for (int i = 1; i < n; i++)
      chk(out_cyc_q[i] - out_cyc_q[i-1] == 2 + 3*nr_of(kl), {"R6 block period ", tag},
          128'(out_cyc_q[i] - out_cyc_q[i-1]), 128'(2 + 3*nr_of(kl)));
    drain();
  endtask

  logic [255:0] k_seq;

  initial begin
    logic [7:0] inv, b;
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int c = 1; c < 256; c++) if (tmul(8'(a), 8'(c)) == 8'h01) inv = 8'(c);
      for (int i = 0; i < 8; i++)
        b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i);
      tsb[a] = b;
    end
    for (int i = 0; i < 32; i++) k_seq[255-8*i -: 8] = 8'(i);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid after reset", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R8 in_ready after reset", 128'(in_ready), 128'(1));

    build_keys({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 4);
    kat(128'h3243f6a8885a308d313198a2e0370734, 2'b00, 128'h3925841d02dc09fbdc118597196a0b32, "k128 a");
    build_keys({k_seq[255:128], 128'h0}, 4);
    kat(128'h00112233445566778899aabbccddeeff, 2'b00, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "k128 b");
    build_keys({k_seq[255:64], 64'h0}, 6);
    kat(128'h00112233445566778899aabbccddeeff, 2'b01, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, "k192");
    build_keys(k_seq, 8);
    kat(128'h00112233445566778899aabbccddeeff, 2'b10, 128'h8ea2b7ca516745bfeafc49904b496089, "k256");
    // R1: reserved code 2'b11 also runs 14 rounds
    kat(128'h00112233445566778899aabbccddeeff, 2'b11, 128'h8ea2b7ca516745bfeafc49904b496089, "k256 code3");

    // R6 / R5 / R9: continuous streams with junk while full
    stream(4, 2'b10, "k256");
    build_keys({k_seq[255:64], 64'h0}, 6);
    stream(3, 2'b01, "k192");
    build_keys({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 4);
    stream(5, 2'b00, "k128");

    // R10: code changed after acceptance of a waiting block
    send(128'h0123456789abcdef0011223344556677, 2'b00);
    send(128'hfedcba98765432100f0e0d0c0b0a0908, 2'b00);
    in_klen = 2'b10;
    while (out_cyc_q.size() < 2) @(negedge clk);
    chk(out_cyc_q[1] - out_cyc_q[0] == 32, "R10 captured key-length code",
        128'(out_cyc_q[1] - out_cyc_q[0]), 128'(32));
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule